// File: doc/BRIEF.md
# Constant-Delay TDM Time-Slot Interchanger

This block switches 8-bit channels between time slots of one serial TDM stream. Every incoming frame is written into one of three data-memory banks, which rotate on each frame pulse. The outgoing frame is read from the bank filled two frames earlier. A connection memory, with one entry per output slot, names the input slot whose byte appears in that output slot.

Because the bank being read is always two frames old, a byte received in frame N leaves in frame N+2 for every slot mapping. The latency in slots is therefore S + (S - IN) + (OUT - 1), where IN and OUT are 1-based slot numbers. At 32 slots per frame this ranges from 32 slots (input 32 to output 1) to 94 slots (input 1 to output 32).

The frame size is 32, 64 or 128 slots, chosen by a rate select input and taken at each frame pulse. The three sizes correspond to 2.048, 4.096 and 8.192 Mb/s lines.

Top module: `tdm_tsi`

## Requirements
- R1: `frame_pulse_i` is high during the bit period that precedes bit 0 of slot 0. The rate code is sampled at that same clock edge and holds for the whole frame; changes on `rate_sel_i` between pulses have no effect. Rate codes: 0 gives 32 slots, 1 gives 64 slots, 2 or 3 gives 128 slots.
- R2: Each slot carries 8 bits, most significant bit first, one bit per clock on both `ser_i` and `ser_o`.
- R3: Take any output slot j whose connection entry selects input slot i. In output frame N+2, slot j carries the byte received in input slot i of frame N.
- R4: `ser_o` is held at 1 until the third frame pulse after reset. That is the point when two complete frames have been received.
- R5: A write with `cm_we_i` high stores `cm_src_i` at entry `cm_addr_i` at that clock edge. The new entry is used from the next bit period on, including later slots of the current frame.
- R6: A connection entry is taken modulo the current frame size: only its low bits select the input slot.
- R7: If no frame pulse arrives, the bit position wraps from the last bit of the last slot back to slot 0, bit 0. The bank in use does not change.
- R8: Reset drives `ser_o` to 1 and clears every connection entry to 0, so after reset every output slot takes input slot 0.
- R9: At 32 slots per frame, input slot 32 switched to output slot 1 leaves 32 slots after it ends. Input slot 1 switched to output slot 32 leaves 94 slots after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_pulse_i | input | 1 | High during the last bit period of a frame |
| rate_sel_i | input | 2 | Frame size code, sampled at the frame pulse |
| ser_i | input | 1 | Serial input stream |
| ser_o | output | 1 | Serial output stream |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_addr_i | input | 7 | Output slot whose entry is written |
| cm_src_i | input | 7 | Input slot number written to the entry |

## Verification
The hardest case to reach is the constant-delay guarantee at its extremes. It has to hold while connection entries are rewritten in the middle of a frame and while the bank rotation is disturbed by a run with no frame pulses. The stimulus builds that situation in stages:
- It first loads the mappings last-to-first and first-to-last, then fills the remaining entries with values larger than the frame size.
- It streams random bytes, rewriting entries inside frames and moving the rate code away from its value between pulses.
- It then withholds the frame pulse for two frame lengths.
- A behavioural model, keyed by frame number, predicts every output bit. Timestamps taken on input and output slot boundaries give the measured delay.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int MaxSlots  = 128;
  localparam int SlotW     = $clog2(MaxSlots);
  localparam int BitW      = 3;
  localparam int PosW      = SlotW + BitW;
  localparam int LatFrames = 2;
  localparam int NumBanks  = LatFrames + 1;
  localparam int BankW     = $clog2(NumBanks);

  typedef enum logic [1:0] {
    RATE_S32  = 2'd0,
    RATE_S64  = 2'd1,
    RATE_S128 = 2'd2
  } rate_e;

  function automatic logic [SlotW-1:0] slot_mask(input logic [1:0] code);
    logic [SlotW-1:0] m;
    case (code)
      RATE_S32: m = SlotW'(31);
      RATE_S64: m = SlotW'(63);
      default:  m = SlotW'(127);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_pulse_i,
  input  logic [1:0]       rate_i,
  output logic [PosW-1:0]  pos_o,
  output logic [PosW-1:0]  last_pos_o,
  output logic [SlotW-1:0] mask_o,
  output logic [BankW-1:0] wr_bank_o,
  output logic [BankW-1:0] rd_bank_o,
  output logic             valid_o
);
  localparam int CntW = $clog2(LatFrames + 2);
  localparam logic [CntW-1:0] CntTop = CntW'(LatFrames + 1);

  logic [PosW-1:0]  pos_q;
  logic [SlotW-1:0] mask_q;
  logic [BankW-1:0] wr_q;
  logic [CntW-1:0]  fcnt_q;
  logic [PosW-1:0]  last_pos;

  assign last_pos = {mask_q, {BitW{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mask_q <= slot_mask(RATE_S32);
      wr_q   <= '0;
      fcnt_q <= '0;
    end else if (frame_pulse_i) begin
      pos_q  <= '0;
      mask_q <= slot_mask(rate_i);
      wr_q   <= (wr_q == BankW'(NumBanks - 1)) ? '0 : wr_q + 1'b1;
      if (fcnt_q != CntTop) fcnt_q <= fcnt_q + 1'b1;
    end else begin
      pos_q <= (pos_q == last_pos) ? '0 : pos_q + 1'b1;
    end
  end

  // read bank lags write bank by LatFrames, modulo NumBanks
  always_comb begin
    int tmp;
    tmp = int'(wr_q) + NumBanks - LatFrames;
    if (tmp >= NumBanks) tmp = tmp - NumBanks;
    rd_bank_o = BankW'(tmp);
  end

  assign pos_o      = pos_q;
  assign last_pos_o = last_pos;
  assign mask_o     = mask_q;
  assign wr_bank_o  = wr_q;
  assign valid_o    = (fcnt_q == CntTop);
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
  import tsi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ser_i,
  input  logic [BitW-1:0] bit_i,
  output logic            we_o,
  output logic [7:0]      byte_o
);
  logic [6:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[5:0], ser_i};
  end

  assign byte_o = {sh_q, ser_i};
  assign we_o   = (bit_i == {BitW{1'b1}});
endmodule

// File: rtl/tsi_bank.sv
module tsi_bank #(
  parameter int AddrW = 7
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AddrW-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [AddrW-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [2**AddrW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int AddrW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AddrW-1:0] waddr_i,
  input  logic [AddrW-1:0] wdata_i,
  input  logic [AddrW-1:0] raddr_i,
  output logic [AddrW-1:0] rdata_o
);
  localparam int Depth = 2**AddrW;
  logic [AddrW-1:0] ent_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/tdm_tsi.sv
module tdm_tsi
  import tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_pulse_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             ser_i,
  output logic             ser_o,
  input  logic             cm_we_i,
  input  logic [SlotW-1:0] cm_addr_i,
  input  logic [SlotW-1:0] cm_src_i
);
  logic [PosW-1:0]  pos;
  logic [PosW-1:0]  last_pos;
  logic [SlotW-1:0] mask;
  logic [BankW-1:0] wr_bank;
  logic [BankW-1:0] rd_bank;
  logic             valid;
  logic [SlotW-1:0] slot;
  logic [BitW-1:0]  bit_idx;
  logic             rx_we;
  logic [7:0]       rx_byte;
  logic [SlotW-1:0] cm_entry;
  logic [SlotW-1:0] src_slot;
  logic [7:0]       bank_rd [NumBanks];
  logic [7:0]       rd_byte;

  assign slot    = pos[PosW-1:BitW];
  assign bit_idx = pos[BitW-1:0];

  tsi_timing u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_pulse_i(frame_pulse_i),
    .rate_i       (rate_sel_i),
    .pos_o        (pos),
    .last_pos_o   (last_pos),
    .mask_o       (mask),
    .wr_bank_o    (wr_bank),
    .rd_bank_o    (rd_bank),
    .valid_o      (valid)
  );

  tsi_rx u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ser_i (ser_i),
    .bit_i (bit_idx),
    .we_o  (rx_we),
    .byte_o(rx_byte)
  );

  tsi_cmem #(.AddrW(SlotW)) u_cmem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cm_we_i),
    .waddr_i(cm_addr_i),
    .wdata_i(cm_src_i),
    .raddr_i(slot),
    .rdata_o(cm_entry)
  );

  assign src_slot = cm_entry & mask;

  for (genvar g = 0; g < NumBanks; g++) begin : g_bank
    tsi_bank #(.AddrW(SlotW)) u_bank (
      .clk_i  (clk_i),
      .we_i   (rx_we && (wr_bank == BankW'(g))),
      .waddr_i(slot),
      .wdata_i(rx_byte),
      .raddr_i(src_slot),
      .rdata_o(bank_rd[g])
    );
  end

  always_comb begin
    rd_byte = '1;
    for (int g = 0; g < NumBanks; g++) begin
      if (rd_bank == BankW'(g)) rd_byte = bank_rd[g];
    end
  end

  assign ser_o = valid ? rd_byte[3'd7 - bit_idx] : 1'b1;
endmodule

// File: rtl/tdm_tsi_chk.sv
module tdm_tsi_chk
  import tsi_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_pulse_i,
  input logic             ser_o,
  input logic             valid_i,
  input logic [PosW-1:0]  pos_i,
  input logic [PosW-1:0]  last_pos_i,
  input logic [BankW-1:0] wr_bank_i,
  input logic [BankW-1:0] rd_bank_i
);
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ser_o);

  p_fp_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> (pos_i == '0));

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_pulse_i && pos_i == last_pos_i) |=> (pos_i == '0));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_pulse_i && pos_i != last_pos_i) |=> (pos_i == PosW'($past(pos_i) + 1'b1)));

  p_rotate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> (wr_bank_i != $past(wr_bank_i)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i |=> $stable(wr_bank_i));

  p_sep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_bank_i != wr_bank_i) && (int'(wr_bank_i) < NumBanks) && (int'(rd_bank_i) < NumBanks));
endmodule

bind tdm_tsi tdm_tsi_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_pulse_i(frame_pulse_i),
  .ser_o        (ser_o),
  .valid_i      (valid),
  .pos_i        (pos),
  .last_pos_i   (last_pos),
  .wr_bank_i    (wr_bank),
  .rd_bank_i    (rd_bank)
);

// File: tb/tb_tdm_tsi.sv
`timescale 1ns/1ps
module tb_tdm_tsi;
  localparam real CLK_NS = 8.0;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_pulse_i = 1'b0;
  logic [1:0] rate_sel_i = 2'd0;
  logic       ser_i = 1'b0;
  logic       ser_o;
  logic       cm_we_i = 1'b0;
  logic [6:0] cm_addr_i = '0;
  logic [6:0] cm_src_i = '0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  tdm_tsi dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_pulse_i(frame_pulse_i),
    .rate_sel_i(rate_sel_i), .ser_i(ser_i), .ser_o(ser_o),
    .cm_we_i(cm_we_i), .cm_addr_i(cm_addr_i), .cm_src_i(cm_src_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string seg_tag = "R3";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic int slots_of(input logic [1:0] r);
    return (r == 2'd0) ? 32 : (r == 2'd1) ? 64 : 128;
  endfunction

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int m_pos = 0, m_S = 32, m_frame = -1;
  logic [7:0] m_sh = '0;
  logic [6:0] m_cm [128];
  logic [7:0] rx [int];
  int tin [int];
  int tout [int];
  logic [7:0] obyte [int];
  logic [7:0] obits = '0;
  logic [7:0] drv [int];

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_pos = 0; m_S = 32; m_frame = -1; m_sh = '0;
      for (int i = 0; i < 128; i++) m_cm[i] = '0;
      rx.delete(); tin.delete(); tout.delete(); obyte.delete();
    end else begin
      if (m_pos % 8 == 7 && m_frame >= 0) begin
        rx[m_frame*256 + m_pos/8] = {m_sh[6:0], ser_i};
        tin[m_frame*256 + m_pos/8] = cyc;
      end
      m_sh = {m_sh[6:0], ser_i};
      if (cm_we_i) m_cm[cm_addr_i] = cm_src_i;
      if (frame_pulse_i) begin
        m_pos = 0; m_S = slots_of(rate_sel_i); m_frame++;
      end else begin
        m_pos = (m_pos + 1) % (m_S * 8);
      end
      if (m_pos % 8 == 0 && m_frame >= 0) tout[m_frame*256 + m_pos/8] = cyc;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic exp;
      string tag;
      exp = 1'b1;
      tag = "R4";
      if (m_frame >= 2) begin
        int src, key;
        src = int'(m_cm[m_pos/8]) % m_S;
        key = (m_frame - 2)*256 + src;
        exp = rx.exists(key) ? rx[key][7 - m_pos%8] : 1'bx;
        tag = seg_tag;
      end
      chk(ser_o === exp, tag, {31'd0, ser_o}, {31'd0, exp});
      obits = {obits[6:0], ser_o};
      if (m_pos % 8 == 7 && m_frame >= 0) obyte[m_frame*256 + m_pos/8] = obits;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset;
    @(negedge clk_i);
    rst_ni = 1'b0; frame_pulse_i = 1'b0; cm_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(ser_o === 1'b1, "R8 idle in reset", {31'd0, ser_o}, 32'd1);
    rst_ni = 1'b1;
  endtask

  task automatic cm_write(input int addr, input int data);
    @(negedge clk_i);
    frame_pulse_i = 1'b0;
    ser_i = 1'($urandom);
    cm_we_i = 1'b1; cm_addr_i = 7'(addr); cm_src_i = 7'(data);
  endtask

  task automatic idle_bits(input int n, input bit pulse_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cm_we_i = 1'b0;
      ser_i = 1'($urandom);
      frame_pulse_i = pulse_last && (i == n - 1);
    end
  endtask

  task automatic drive_frame(input int f, input logic [1:0] rate, input bit cmw, input bit glitch);
    int S;
    logic [7:0] cur;
    S = slots_of(rate);
    cur = '0;
    for (int p = 0; p < S*8; p++) begin
      @(negedge clk_i);
      if (p % 8 == 0) begin
        cur = 8'($urandom);
        drv[f*256 + p/8] = cur;
      end
      ser_i = cur[7 - p%8];
      frame_pulse_i = (p == S*8 - 1);
      cm_we_i = 1'b0;
      if (cmw && (p % 41 == 3)) begin
        cm_we_i = 1'b1;
        cm_addr_i = 7'($urandom % S);
        cm_src_i = 7'($urandom);
      end
      rate_sel_i = (glitch && p >= S*4 && p < S*8 - 1) ? (rate ^ 2'b01) : rate;
    end
  endtask

  initial begin
    // segment 1: 32 slots, extreme mappings, oversized entries, mid-frame writes
    rate_sel_i = 2'd0;
    do_reset();
    cm_write(0, 31);
    cm_write(31, 0);
    for (int a = 1; a < 31; a++) cm_write(a, int'($urandom % 128));
    idle_bits(1, 1'b1);
    drv.delete();
    seg_tag = "R6";
    for (int f = 0; f < 4; f++) drive_frame(f, 2'd0, 1'b0, 1'b0);
    seg_tag = "R5";
    for (int f = 4; f < 6; f++) drive_frame(f, 2'd0, 1'b1, 1'b0);

    // R9 / R2: extreme delays and MSB-first byte order
    chk(obyte.exists(512) && obyte[512] == drv[31], "R2 out slot1 byte = in slot32 byte",
        obyte.exists(512) ? {24'd0, obyte[512]} : 32'hx, {24'd0, drv[31]});
    chk(obyte.exists(543) && obyte[543] == drv[0], "R3 out slot32 byte = in slot1 byte",
        obyte.exists(543) ? {24'd0, obyte[543]} : 32'hx, {24'd0, drv[0]});
    chk(tout.exists(512) && tin.exists(31) && (tout[512] - tin[31]) == 32*8,
        "R9 min delay cycles", 32'(tout[512] - tin[31]), 32'd256);
    chk(tout.exists(543) && tin.exists(0) && (tout[543] - tin[0]) == 94*8,
        "R9 max delay cycles", 32'(tout[543] - tin[0]), 32'd752);

    // free-running wrap without frame pulse
    seg_tag = "R7";
    idle_bits(2*256, 1'b0);
    idle_bits(256, 1'b1);
    idle_bits(256, 1'b1);
    idle_bits(256, 1'b1);

    // segment 2: 64 slots, cleared entries, rate glitches between pulses
    rate_sel_i = 2'd1;
    do_reset();
    cm_write(3, 60);
    cm_write(40, 7);
    idle_bits(1, 1'b1);
    seg_tag = "R8";
    for (int f = 0; f < 3; f++) drive_frame(f, 2'd1, 1'b0, 1'b0);
    seg_tag = "R1";
    for (int f = 3; f < 6; f++) drive_frame(f, 2'd1, 1'b1, 1'b1);

    // segment 3: 128 slots, full random map
    rate_sel_i = 2'd2;
    do_reset();
    for (int a = 0; a < 128; a++) cm_write(a, int'($urandom % 128));
    idle_bits(1, 1'b1);
    seg_tag = "R3";
    for (int f = 0; f < 5; f++) drive_frame(f, 2'd2, 1'b1, 1'b0);
    idle_bits(4, 1'b0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule